// File: doc/BRIEF.md
# Parallel-to-Serial Converter with Overrun Detection

This block takes a W-bit parallel word and sends it out as a serial stream, one bit per clock, most significant bit first. A load strobe that is sampled while the converter is free captures the word into an internal shift register. From the next cycle on, the block presents one bit per cycle for W cycles and raises a busy flag for that whole window.

A strobe that arrives while a word is still being sent is a protocol violation. The block refuses that word and produces a one-cycle overrun pulse. The word already in progress goes on unchanged. A strobe during the final bit cycle of a word is legal. This lets words follow one another with no gap cycle, which gives the peak rate of one word every W clocks.

Top module: `word_serializer`

## Requirements
- R1: When `rst` is high at a rising clock edge, the next cycle shows `busy_o`, `ser_o` and `overrun_o` all at 0. Reset is synchronous.
- R2: While `busy_o` is 0, `ser_o` is held at 0.
- R3: If `load_i` is high at an edge while the block is idle, `word_i` is captured. During the W cycles that follow, `ser_o` shows `word_i[W-1]`, `word_i[W-2]`, and so on down to `word_i[0]`, one bit per cycle.
- R4: `busy_o` is 1 for exactly the W cycles that carry the bits of an accepted word. It returns to 0 after them unless another word is accepted.
- R5: If `load_i` is high during the cycle that shows bit 0 of the current word, the new word is accepted. Its MSB appears in the very next cycle, with no idle cycle between the words and no overrun.
- R6: If `load_i` is high during any other cycle in which `busy_o` is 1, `overrun_o` is 1 in the following cycle only. `overrun_o` is 0 in every other case.
- R7: A refused word is dropped. The bits and the busy window of the word in progress are the same as they would be without the refused strobe.
- R8: The word width W is a parameter with a default of 8. With W=8 and word 8'b00000100, `ser_o` gives 0 for five cycles, then 1 for one cycle, then 0 for two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe for `word_i` |
| word_i | input | W | Parallel word to send |
| ser_o | output | 1 | Serial data, MSB first, 0 when idle |
| busy_o | output | 1 | High while a word's bits are on `ser_o` |
| overrun_o | output | 1 | One-cycle pulse after a refused strobe |

## Verification
The bench builds one instance with W=4. That keeps the space small enough to send all 16 words, each one alone, after every possible refused-strobe position, and chained back to back with its successor. Every bit position therefore meets every strobe timing. A second instance uses the default W=8 and checks the stated 8'b00000100 pattern, a chained pair, and a refused strobe at full width. A reset applied mid-word confirms the synchronous return to idle.

// File: rtl/word_serializer.sv
module word_serializer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic         ser_o,
  output logic         busy_o,
  output logic         overrun_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          err_q;

  wire last   = busy_q && (cnt_q == '0);
  wire accept = load_i && (!busy_q || last);
  wire refuse = load_i && busy_q && !last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= refuse;
      if (accept) begin
        sh_q   <= word_i;
        cnt_q  <= CW'(W - 1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        sh_q   <= sh_q << 1;
        cnt_q  <= cnt_q - CW'(1);
        busy_q <= !last;
      end
    end
  end

  assign ser_o     = busy_q & sh_q[W-1];
  assign busy_o    = busy_q;
  assign overrun_o = err_q;

  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !ser_o);

  p_msb_first_r3: assert property (@(posedge clk) disable iff (rst)
    (load_i && !busy_o) |=> (busy_o && ser_o == $past(word_i[W-1])));

  p_busy_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (last && !load_i) |=> !busy_o);

  p_chain_r5: assert property (@(posedge clk) disable iff (rst)
    (last && load_i) |=> (busy_o && !overrun_o && ser_o == $past(word_i[W-1])));

  p_overrun_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    refuse |=> overrun_o);

  p_overrun_cause_r6: assert property (@(posedge clk) disable iff (rst)
    overrun_o |-> ($past(load_i) && $past(busy_o)));

  p_refused_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    refuse |=> busy_o);
endmodule

// File: tb/test_word_serializer.sv
module test_word_serializer;
  localparam int W = 4;
  localparam int V = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld = 1'b0;
  logic [W-1:0] din = '0;
  logic ser, busy, ovr;
  logic ld8 = 1'b0;
  logic [V-1:0] din8 = '0;
  logic ser8, busy8, ovr8;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  word_serializer #(.W(W)) i_word_serializer (
    .clk(clk), .rst(rst), .load_i(ld), .word_i(din),
    .ser_o(ser), .busy_o(busy), .overrun_o(ovr));

  word_serializer #(.W(V)) i_word_serializer_w8 (
    .clk(clk), .rst(rst), .load_i(ld8), .word_i(din8),
    .ser_o(ser8), .busy_o(busy8), .overrun_o(ovr8));

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {ser,busy,ovr} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Entered at a negedge with ld driven to w. inj: position of a refused strobe (-1 none).
  task automatic stream(input logic [W-1:0] w, input int inj, input logic [W-1:0] injw,
                        input bit chain, input logic [W-1:0] nxt);
    @(posedge clk); @(negedge clk); ld = 1'b0;
    for (int k = 0; k < W; k++) begin
      chk((k > 0 && inj == k - 1) ? "R3/R4/R6/R7" : "R3/R4",
          {ser, busy, ovr}, {w[W-1-k], 1'b1, (k > 0 && inj == k - 1)});
      if (k == inj) begin ld = 1'b1; din = injw; end
      if (chain && k == W - 1) begin ld = 1'b1; din = nxt; end
      if (!(chain && k == W - 1)) begin
        @(posedge clk); @(negedge clk); ld = 1'b0;
      end
    end
    if (!chain) chk("R2/R4", {ser, busy, ovr}, 3'b000);
  endtask

  initial begin
    logic [V-1:0] pat;
    @(negedge clk); @(negedge clk);
    chk("R1", {ser, busy, ovr}, 3'b000);
    chk("R1", {ser8, busy8, ovr8}, 3'b000);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", {ser, busy, ovr}, 3'b000);

    for (int w = 0; w < (1 << W); w++) begin
      ld = 1'b1; din = W'(w);
      stream(W'(w), -1, '0, 1'b0, '0);
      for (int j = 0; j < W - 1; j++) begin
        ld = 1'b1; din = W'(w);
        stream(W'(w), j, ~W'(w), 1'b0, '0);
      end
      ld = 1'b1; din = W'(w);
      stream(W'(w), -1, '0, 1'b1, W'(w + 5));
      stream(W'(w + 5), -1, '0, 1'b0, '0);
    end

    // R1: reset mid-word
    ld = 1'b1; din = '1;
    @(posedge clk); @(negedge clk); ld = 1'b0;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", {ser, busy, ovr}, 3'b000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1/R2", {ser, busy, ovr}, 3'b000);

    // R8: default width example, then a chained word, then a refused strobe
    ld8 = 1'b1; din8 = 8'b00000100;
    @(posedge clk); @(negedge clk); ld8 = 1'b0;
    for (int k = 0; k < V; k++) begin
      chk("R8", {ser8, busy8, ovr8}, {(k == 5), 1'b1, 1'b0});
      if (k == V - 1) begin ld8 = 1'b1; din8 = 8'hA7; end
      @(posedge clk); @(negedge clk); ld8 = 1'b0;
    end
    pat = 8'hA7;
    for (int k = 0; k < V; k++) begin
      chk("R5/R8", {ser8, busy8, ovr8}, {pat[V-1-k], 1'b1, (k == 4)});
      if (k == 3) begin ld8 = 1'b1; din8 = 8'h00; end
      @(posedge clk); @(negedge clk); ld8 = 1'b0;
    end
    chk("R7/R8", {ser8, busy8, ovr8}, 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule